// File: doc/BRIEF.md
# Line-Based Timer Interrupt Unit

This block is the interrupt timer of a video controller. A 32-bit down-counter steps once for each pixel-clock enable. When it runs out it can raise a timer interrupt and reload itself. The reload value is loaded through two 16-bit register writes. A mode register selects when the counter reloads, enables the timer interrupt and controls a small auto-animation counter that steps once per frame group. Reading the same register index returns the current raster line, the 50/60 Hz flag and the animation counter.

Three interrupt sources stay pending until software acknowledges them. These are the timer, the start of vertical blanking and an auxiliary event. Software clears them by writing ones to an acknowledge register. Raster timing is not generated here: the line number, the PAL flag, the pixel enable and the start-of-blanking strobe come in as inputs. In PAL mode, a stop bit can hold the counter still for 16 lines at the top of the frame and 16 lines at the bottom.

Top module: `line_timer_irq`

## Requirements
- R1: Writes are decoded by the 3-bit word index `regAddr`: 3 = mode, 4 = reload high half, 5 = reload low half, 6 = acknowledge, 7 = timer stop. Writes to indices 0..2 change no state.
- R2: A mode write stores the animation speed from bits 15..8, the reload mode from bits 7..5, the timer interrupt enable from bit 4 and the animation disable from bit 3. After reset all of these fields are 0.
- R3: While `regAddr` is 3, `regRdData` shows the raster line in bits 15..7, zeros in bits 6..4, `palMode` in bit 3 and the animation counter in bits 2..0. Any other index reads 0.
- R4: Each cycle with `pixEn` set, the counter steps down by one. A step taken at count 1 is an expiry, and it sets the timer pending flag if the interrupt enable is 1. A counter at 0 stays at 0.
- R5: When mode bit 7 is 1, an expiry reloads the counter with {high half, low half} instead of leaving it at 0.
- R6: When mode bit 5 is 1, a low-half write loads the counter with {stored high half, written data}. This load takes priority over any other counter update in that cycle. When bit 5 is 0, the counter is left unchanged.
- R7: When mode bit 6 is 1, a `vblankStart` pulse reloads the counter from the stored reload value.
- R8: `pendFlags` holds three flags: bit 2 is set by `vblankStart`, bit 1 by a timer expiry and bit 0 by `auxIrqEvent`. Each flag stays set until it is acknowledged. `irqOut` is 1 whenever any flag is set.
- R9: Writing to the acknowledge register clears each pending flag whose data bit (2, 1 or 0) is 1 and leaves the other flags unchanged. If a flag is set and acknowledged in the same cycle, it stays set.
- R10: When bit 0 of the stop register is 1 and `palMode` is 1, the counter does not step on lines 0..15 or on lines 296..311 of the 312-line frame.
- R11: When animation is enabled, each `vblankStart` advances a frame count. The 3-bit animation counter increments and wraps after every speed+1 pulses. A mode write restarts the frame count. When bit 3 is set, the animation counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word index |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for the selected index |
| pixEn | input | 1 | Pixel-clock enable, one counter step |
| lineNum | input | 9 | Current raster line |
| palMode | input | 1 | 1 = 50 Hz frame |
| vblankStart | input | 1 | One-cycle pulse at start of vertical blanking |
| auxIrqEvent | input | 1 | One-cycle pulse from the auxiliary interrupt source |
| pendFlags | output | 3 | Pending flags {vblank, timer, aux} |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench sweeps reload values 1 to 20 and checks that the flag is still clear one step before expiry and set on the expiry step. This tells an off-by-one count apart from a correct one. It also checks that periodic reload and a one-shot that stops at zero behave differently. Every line from 0 to 311 is tried with the stop bit set in PAL mode, which pins down both edges of the frozen border, and the non-PAL and stop-clear cases are checked as well. Animation speeds 0 to 4 are each driven with twelve blanking pulses and compared against floor(pulses/(speed+1)) mod 8. A reload value of 0x0001_0000 shows that the high half is used.

// File: rtl/lti_pkg.sv
package lti_pkg;
  localparam logic [2:0] IDX_MODE = 3'd3;
  localparam logic [2:0] IDX_RLD_HI = 3'd4;
  localparam logic [2:0] IDX_RLD_LO = 3'd5;
  localparam logic [2:0] IDX_ACK = 3'd6;
  localparam logic [2:0] IDX_STOP = 3'd7;

  localparam int unsigned SRC_AUX = 0;
  localparam int unsigned SRC_TIMER = 1;
  localparam int unsigned SRC_VBL = 2;
  localparam int unsigned NUM_SRC = 3;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic reloadOnLo;
    logic reloadOnBlank;
    logic reloadOnExpiry;
    logic tick;
    logic timerIrqEn;
    logic [NUM_SRC-1:0] ackMask;
  } tmrStrobes_t;
endpackage

// File: rtl/lti_ctrl.sv
module lti_ctrl
  import lti_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LINE_W = 9,
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned BORDER_LINES = 16,
  parameter int unsigned ANIM_W = 3,
  parameter int unsigned SPEED_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              pixEn,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              palMode,
  input  logic              vblankStart,
  output tmrStrobes_t       strb
);
  localparam int unsigned PAD_W = DATA_W - LINE_W - 1 - ANIM_W;
  localparam logic [LINE_W-1:0] TOP_END = LINE_W'(BORDER_LINES);
  localparam logic [LINE_W-1:0] BOT_START = LINE_W'(LINES_PER_FRAME - BORDER_LINES);

  logic [SPEED_W-1:0] speedReg;
  logic [2:0]         reloadMode;
  logic               irqEnReg;
  logic               animOff;
  logic               stopReg;
  logic [SPEED_W-1:0] frameCnt;
  logic [ANIM_W-1:0]  animCnt;

  logic wrMode, wrStop, wrAck, inBorder, frozen;

  assign wrMode = regWrEn && (regAddr == IDX_MODE);
  assign wrStop = regWrEn && (regAddr == IDX_STOP);
  assign wrAck  = regWrEn && (regAddr == IDX_ACK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      speedReg   <= '0;
      reloadMode <= '0;
      irqEnReg   <= 1'b0;
      animOff    <= 1'b0;
      stopReg    <= 1'b0;
    end else begin
      if (wrMode) begin
        speedReg   <= regWrData[15:8];
        reloadMode <= regWrData[7:5];
        irqEnReg   <= regWrData[4];
        animOff    <= regWrData[3];
      end
      if (wrStop) stopReg <= regWrData[0];
    end
  end

  // border freeze window
  assign inBorder = (lineNum < TOP_END) || (lineNum >= BOT_START);
  assign frozen   = stopReg && palMode && inBorder;

  // animation counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      animCnt  <= '0;
    end else if (wrMode) begin
      frameCnt <= '0;
    end else if (vblankStart && !animOff) begin
      if (frameCnt == speedReg) begin
        frameCnt <= '0;
        animCnt  <= animCnt + 1'b1;
      end else begin
        frameCnt <= frameCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb = '0;
    strb.loadHi         = regWrEn && (regAddr == IDX_RLD_HI);
    strb.loadLo         = regWrEn && (regAddr == IDX_RLD_LO);
    strb.reloadOnLo     = strb.loadLo && reloadMode[0];
    strb.reloadOnBlank  = vblankStart && reloadMode[1];
    strb.reloadOnExpiry = reloadMode[2];
    strb.tick           = pixEn && !frozen;
    strb.timerIrqEn     = irqEnReg;
    strb.ackMask        = wrAck ? regWrData[NUM_SRC-1:0] : '0;
  end

  always_comb begin
    if (regAddr == IDX_MODE)
      regRdData = {lineNum, {PAD_W{1'b0}}, palMode, animCnt};
    else
      regRdData = '0;
  end

  // R11: animation counter holds unless a blanking pulse arrives
  p_anim_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !vblankStart |=> $stable(animCnt));
  // R11: disabled animation holds its counter
  p_anim_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (animOff && !wrMode) |=> $stable(animCnt));
endmodule

// File: rtl/lti_datapath.sv
module lti_datapath
  import lti_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobes_t        strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               vblankStart,
  input  logic               auxIrqEvent,
  output logic [NUM_SRC-1:0] pendFlags,
  output logic               irqOut
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [DATA_W-1:0] reloadHi, reloadLo;
  logic [CNT_W-1:0]  count;
  logic              expiry;
  logic [NUM_SRC-1:0] setBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadHi <= '0;
      reloadLo <= '0;
    end else begin
      if (strb.loadHi) reloadHi <= wrData;
      if (strb.loadLo) reloadLo <= wrData;
    end
  end

  assign expiry = strb.tick && (count == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.reloadOnLo) begin
      count <= {reloadHi, wrData};
    end else if (strb.reloadOnBlank) begin
      count <= {reloadHi, reloadLo};
    end else if (expiry) begin
      count <= strb.reloadOnExpiry ? {reloadHi, reloadLo} : '0;
    end else if (strb.tick && (count != '0)) begin
      count <= count - CNT_ONE;
    end
  end

  always_comb begin
    setBits = '0;
    setBits[SRC_VBL]   = vblankStart;
    setBits[SRC_TIMER] = expiry && strb.timerIrqEn;
    setBits[SRC_AUX]   = auxIrqEvent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendFlags <= '0;
    else       pendFlags <= (pendFlags & ~strb.ackMask) | setBits;
  end

  assign irqOut = |pendFlags;

  // R9: acknowledged blanking flag clears when no new pulse arrives
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackMask[SRC_VBL] && !vblankStart) |=> !pendFlags[SRC_VBL]);
  // R8: an aux flag persists until acknowledged
  p_hold_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlags[SRC_AUX] && !strb.ackMask[SRC_AUX]) |=> pendFlags[SRC_AUX]);
  // R4: an idle counter stays at zero without a load
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !strb.reloadOnLo && !strb.reloadOnBlank) |=> (count == '0));
  // R10: without a step or load the counter is held
  p_halt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.reloadOnLo && !strb.reloadOnBlank) |=> $stable(count));
endmodule

// File: rtl/line_timer_irq.sv
module line_timer_irq
  import lti_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LINE_W = 9,
  parameter int unsigned LINES_PER_FRAME = 312,
  parameter int unsigned BORDER_LINES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              pixEn,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              palMode,
  input  logic              vblankStart,
  input  logic              auxIrqEvent,
  output logic [2:0]        pendFlags,
  output logic              irqOut
);
  tmrStrobes_t strb;

  lti_ctrl #(
    .DATA_W(DATA_W), .LINE_W(LINE_W), .LINES_PER_FRAME(LINES_PER_FRAME),
    .BORDER_LINES(BORDER_LINES), .ANIM_W(3), .SPEED_W(8)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pixEn(pixEn),
    .lineNum(lineNum), .palMode(palMode), .vblankStart(vblankStart),
    .strb(strb)
  );

  lti_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .vblankStart(vblankStart), .auxIrqEvent(auxIrqEvent),
    .pendFlags(pendFlags), .irqOut(irqOut)
  );
endmodule

// File: tb/line_timer_irq_test.sv
module line_timer_irq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = 3'd3;
  logic regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic pixEn = 1'b0;
  logic [8:0] lineNum = '0;
  logic palMode = 1'b0;
  logic vblankStart = 1'b0;
  logic auxIrqEvent = 1'b0;
  logic [2:0] pendFlags;
  logic irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_timer_irq uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pixEn(pixEn),
    .lineNum(lineNum), .palMode(palMode), .vblankStart(vblankStart),
    .auxIrqEvent(auxIrqEvent), .pendFlags(pendFlags), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    regAddr = idx; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd3;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    pixEn = 1'b1;
    repeat (n) @(negedge clk);
    pixEn = 1'b0;
  endtask

  task automatic vbl();
    @(negedge clk);
    vblankStart = 1'b1;
    @(negedge clk);
    vblankStart = 1'b0;
  endtask

  task automatic pulseAux();
    @(negedge clk);
    auxIrqEvent = 1'b1;
    @(negedge clk);
    auxIrqEvent = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int a0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3 reset state
    chk(regRdData == 16'h0000, "R3 reset read", regRdData, 0);
    chk(irqOut == 1'b0 && pendFlags == 3'b000, "R2 reset pending", pendFlags, 0);

    // R3 readback layout
    for (int l = 0; l < 312; l += 37) begin
      lineNum = 9'(l); palMode = l[0];
      @(negedge clk);
      chk(regRdData == {9'(l), 3'b000, l[0], 3'b000}, "R3 status layout", regRdData,
          {9'(l), 3'b000, l[0], 3'b000});
    end
    regAddr = 3'd5;
    @(negedge clk);
    chk(regRdData == 16'h0, "R3 other index reads 0", regRdData, 0);
    regAddr = 3'd3; lineNum = '0; palMode = 1'b0;

    // R2: reset interrupt enable off -> expiry raises nothing
    wr(3'd5, 16'd3);  // bit5 still 0, counter untouched
    ticks(5);
    chk(pendFlags[1] == 1'b0, "R2 disabled after reset", pendFlags, 0);

    // R4/R5/R6 periodic sweep
    wr(3'd3, 16'h00B0);
    for (int n = 1; n <= 20; n++) begin
      wr(3'd4, 16'h0);
      wr(3'd5, 16'(n));
      wr(3'd6, 16'h0007);
      if (n > 1) begin
        ticks(n - 1);
        chk(irqOut == 1'b0, "R4 before expiry", irqOut, 0);
        ticks(1);
      end else ticks(1);
      chk(pendFlags[1] == 1'b1, "R4 expiry sets timer", pendFlags, 2);
      wr(3'd6, 16'h0002);
      if (n > 1) begin
        ticks(n - 1);
        chk(irqOut == 1'b0, "R5 reload period early", irqOut, 0);
      end
      ticks(1);
      chk(pendFlags[1] == 1'b1, "R5 periodic reload", pendFlags, 2);
      wr(3'd6, 16'h0002);
    end

    // R4 one-shot stops at zero
    wr(3'd3, 16'h0030);
    wr(3'd5, 16'd3);
    ticks(3);
    chk(pendFlags[1] == 1'b1, "R4 one-shot expiry", pendFlags, 2);
    wr(3'd6, 16'h0002);
    ticks(10);
    chk(pendFlags[1] == 1'b0, "R4 idle at zero", pendFlags, 0);

    // R1: writes to index 0..2 ignored
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'hFFFF); wr(3'd2, 16'hFFFF);
    ticks(4);
    chk(pendFlags == 3'b000 && regRdData == 16'h0, "R1 unmapped writes", regRdData, 0);

    // R2: interrupt enable bit clear
    wr(3'd3, 16'h00A0);
    wr(3'd5, 16'd2);
    ticks(2);
    chk(pendFlags[1] == 1'b0, "R2 enable bit 4 clear", pendFlags, 0);

    // R6 no load without bit5, R7 blanking reload
    wr(3'd3, 16'h0030);
    wr(3'd5, 16'd1);
    ticks(1);
    wr(3'd6, 16'h0007);
    wr(3'd3, 16'h0050);
    wr(3'd5, 16'd4);
    ticks(8);
    chk(pendFlags[1] == 1'b0, "R6 no load when bit5 clear", pendFlags, 0);
    vbl();
    chk(pendFlags[2] == 1'b1, "R8 vblank sets flag", pendFlags, 4);
    wr(3'd6, 16'h0004);
    chk(pendFlags[2] == 1'b0, "R9 ack vblank", pendFlags, 0);
    ticks(3);
    chk(pendFlags[1] == 1'b0, "R7 reload early", pendFlags, 0);
    ticks(1);
    chk(pendFlags[1] == 1'b1, "R7 blank reload expiry", pendFlags, 2);

    // R8/R9 per-bit acknowledge
    vbl(); pulseAux();
    chk(pendFlags == 3'b111 && irqOut, "R8 all pending", pendFlags, 7);
    wr(3'd6, 16'h0002);
    chk(pendFlags == 3'b101, "R9 ack timer only", pendFlags, 5);
    wr(3'd6, 16'h0001);
    chk(pendFlags == 3'b100 && irqOut, "R8 irq with one flag", pendFlags, 4);
    wr(3'd6, 16'h0004);
    chk(pendFlags == 3'b000 && !irqOut, "R8 irq clear", pendFlags, 0);

    // R9 set wins over ack in same cycle
    wr(3'd3, 16'h0030);
    wr(3'd5, 16'd2);
    ticks(1);
    @(negedge clk);
    regAddr = 3'd6; regWrData = 16'h0002; regWrEn = 1'b1; pixEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; pixEn = 1'b0; regAddr = 3'd3;
    chk(pendFlags[1] == 1'b1, "R9 set beats ack", pendFlags, 2);
    wr(3'd6, 16'h0002);
    chk(pendFlags[1] == 1'b0, "R9 later ack clears", pendFlags, 0);

    // R10 freeze sweep over every line
    wr(3'd7, 16'h0001);
    palMode = 1'b1;
    for (int l = 0; l < 312; l++) begin
      lineNum = 9'(l);
      wr(3'd5, 16'd1);
      wr(3'd6, 16'h0007);
      ticks(1);
      chk(pendFlags[1] == ((l >= 16 && l < 296) ? 1'b1 : 1'b0), "R10 freeze window",
          pendFlags[1], (l >= 16 && l < 296) ? 1 : 0);
    end
    palMode = 1'b0; lineNum = 9'd0;
    wr(3'd5, 16'd1); wr(3'd6, 16'h0007); ticks(1);
    chk(pendFlags[1] == 1'b1, "R10 no freeze at 60Hz", pendFlags, 2);
    palMode = 1'b1; wr(3'd7, 16'h0000);
    wr(3'd5, 16'd1); wr(3'd6, 16'h0007); ticks(1);
    chk(pendFlags[1] == 1'b1, "R10 no freeze when stop clear", pendFlags, 2);
    palMode = 1'b0;

    // R11 animation sweep
    for (int s = 0; s < 5; s++) begin
      wr(3'd3, 16'(s << 8));
      a0 = int'(regRdData[2:0]);
      for (int f = 1; f <= 12; f++) begin
        vbl();
        chk(int'(regRdData[2:0]) == ((a0 + f / (s + 1)) % 8), "R11 animation step",
            regRdData[2:0], (a0 + f / (s + 1)) % 8);
      end
    end
    wr(3'd3, 16'h0008);
    a0 = int'(regRdData[2:0]);
    repeat (5) vbl();
    chk(int'(regRdData[2:0]) == a0, "R11 animation disabled", regRdData[2:0], a0);
    wr(3'd6, 16'h0007);

    // R6 high half used
    wr(3'd3, 16'h0030);
    wr(3'd4, 16'h0001);
    wr(3'd5, 16'h0000);
    ticks(65535);
    chk(pendFlags[1] == 1'b0, "R6 high half early", pendFlags, 0);
    ticks(1);
    chk(pendFlags[1] == 1'b1, "R6 high half expiry", pendFlags, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule